// File: doc/BRIEF.md
# Range Translation Lookaside Buffer

This block stores a small set of range translations and is consulted when a virtual page number misses in the first-level page TLB. It runs alongside the second-level TLB. Each stored range is a contiguous span of virtual pages with a lower bound and an upper bound. All pages in the span share one additive offset and one set of protection bits. A lookup compares the page number against every entry at once, using two comparators per entry. On a hit, the block returns a page table entry for the first-level TLB. The physical page number is the virtual page number plus the entry's offset, and the protection bits are passed through from the entry.

When no entry covers the page, the block raises a fetch request toward an external range table walker and holds it until the walker accepts it. The walker later writes a range back through the refill port. Refills go to the lowest free slot. When every slot is in use, a rotating pointer picks the slot to replace. A single flush input empties the whole buffer.

Top module: `range_lookaside`

## Requirements
- R1: An entry covers page number V only when base <= V and V < limit. The lower bound is inclusive and the upper bound is exclusive. An empty or inverted span (limit <= base) never hits.
- R2: On a hit, `rsp_ppn` equals the page number zero-extended to the physical width plus the entry offset, modulo 2^PPN_W. `rsp_prot` equals the entry's protection bits unchanged. On a miss, both are zero.
- R3: A lookup presented with `lk_valid` in cycle t produces `rsp_valid` = 1 in cycle t+1 only. `rsp_valid` is 0 in any cycle that does not follow a lookup.
- R4: A missing lookup raises `walk_req` in the same cycle as its response, and `walk_vpn` carries the missing page number. Both are held unchanged until a cycle with `walk_ack` = 1, and `walk_req` drops in the cycle after that. A miss that arrives while a request is outstanding does not start a new request.
- R5: A refill is written into the lowest-numbered invalid slot. A later refill therefore occupies a higher slot than an earlier one while free slots remain.
- R6: When all slots are valid, refills replace slots in rotating order 0, 1, 2, … and wrap after the last slot. The rotation pointer starts at 0 after reset, advances only on such replacements, and is not moved by a flush.
- R7: `flush_all` invalidates every slot, so later lookups miss. A refill in the same cycle as a flush is discarded.
- R8: When several valid entries cover the page, the entry in the lowest-numbered slot supplies the translation.
- R9: After reset, `rsp_valid` and `walk_req` are 0 and every slot is invalid.
- R10: A lookup in the same cycle as a refill or flush sees the contents from before that cycle. The change is visible to lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| rsp_valid | output | 1 | Lookup result is present |
| rsp_hit | output | 1 | Some entry covers the page |
| rsp_ppn | output | PPN_W | Translated physical page number |
| rsp_prot | output | PROT_W | Protection bits of the hitting entry |
| walk_req | output | 1 | Fetch request to the range table walker |
| walk_vpn | output | VPN_W | Page number that missed |
| walk_ack | input | 1 | Walker accepts the pending request |
| fill_valid | input | 1 | Refill write strobe |
| fill_base | input | VPN_W | Refill lower bound (inclusive) |
| fill_limit | input | VPN_W | Refill upper bound (exclusive) |
| fill_offset | input | PPN_W | Refill additive offset |
| fill_prot | input | PROT_W | Refill protection bits |
| flush_all | input | 1 | Invalidate every entry |

## Verification
Lookups are aimed at the exact lower bound, at the last page inside a range and at the first page past it. These cases separate an inclusive comparison from an exclusive one on each side. Overlapping ranges with different offsets show which slot wins a priority decision. More than a full buffer of refills shows whether the free-slot choice and the rotating victim choice are each taken at the right time. A seeded random phase mixes random spans, random offsets that wrap the physical page width, and probes near range edges, all against a bench model. Held, unacknowledged misses followed by a second miss check that the outstanding request stays stable.

// File: rtl/rlb_pkg.sv
package rlb_pkg;
  parameter int VPN_W  = 20;
  parameter int PPN_W  = 20;
  parameter int PROT_W = 4;

  typedef logic [VPN_W-1:0]  vpn_t;
  typedef logic [PPN_W-1:0]  ppn_t;
  typedef logic [PROT_W-1:0] prot_t;

  // two comparators: inclusive low bound, exclusive high bound
  function automatic logic span_covers(vpn_t lo, vpn_t hi, vpn_t v);
    return (lo <= v) && (v < hi);
  endfunction

  // zero-extend the page number, then add the offset modulo 2^PPN_W
  function automatic ppn_t shift_page(vpn_t v, ppn_t ofs);
    ppn_t ext;
    ext = '0;
    ext[VPN_W-1:0] = v;
    return ext + ofs;
  endfunction
endpackage

// File: rtl/rlb_cmp.sv
module rlb_cmp
  import rlb_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic [ENTRIES-1:0]            slot_valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] slot_lo,
  input  logic [ENTRIES-1:0][VPN_W-1:0] slot_hi,
  input  vpn_t                          probe,
  output logic [ENTRIES-1:0]            covers
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign covers[g] = slot_valid[g] & span_covers(slot_lo[g], slot_hi[g], probe);
  end
endmodule

// File: rtl/rlb_pick.sv
module rlb_pick #(
  parameter int ENTRIES = 32,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] covers,
  output logic               any_hit,
  output logic [IDX_W-1:0]   win_idx
);
  logic [ENTRIES-1:0] win_oh;

  // lowest set bit wins
  assign win_oh  = covers & (~covers + ENTRIES'(1));
  assign any_hit = |covers;

  always_comb begin
    win_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (covers[i]) win_idx = IDX_W'(i);
    end
  end

  AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh) && ((win_oh & ~covers) == '0)); // R8
  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> win_oh[win_idx]); // R8
endmodule

// File: rtl/rlb_victim.sv
module rlb_victim #(
  parameter int ENTRIES = 32,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] slot_valid,
  input  logic               write_now,
  output logic [IDX_W-1:0]   target
);
  logic [IDX_W-1:0] rot_q;
  logic [IDX_W-1:0] free_idx;
  logic             all_full;

  assign all_full = &slot_valid;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!slot_valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign target = all_full ? rot_q : free_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rot_q <= '0;
    end else if (write_now && all_full) begin
      if (rot_q == IDX_W'(ENTRIES - 1)) rot_q <= '0;
      else                              rot_q <= rot_q + IDX_W'(1);
    end
  end

  AST_ROT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rot_q <= IDX_W'(ENTRIES - 1)); // R6
  AST_ROT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (write_now && !all_full) |=> $stable(rot_q)); // R6
endmodule

// File: rtl/range_lookaside.sv
module range_lookaside
  import rlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic [PROT_W-1:0] rsp_prot,
  output logic              walk_req,
  output logic [VPN_W-1:0]  walk_vpn,
  input  logic              walk_ack,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_base,
  input  logic [VPN_W-1:0]  fill_limit,
  input  logic [PPN_W-1:0]  fill_offset,
  input  logic [PROT_W-1:0] fill_prot,
  input  logic              flush_all
);
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  lo_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  hi_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ofs_q;
  logic [ENTRIES-1:0][PROT_W-1:0] prot_q;

  logic [ENTRIES-1:0] covers;
  logic               any_hit;
  logic [IDX_W-1:0]   win_idx;
  logic [IDX_W-1:0]   fill_slot;

  // named events for the assertions
  logic fill_fire;
  logic miss_event;
  logic walk_launch;
  logic walk_done;

  assign fill_fire   = fill_valid & ~flush_all;
  assign miss_event  = lk_valid & ~any_hit;
  assign walk_done   = walk_req & walk_ack;
  assign walk_launch = miss_event & ~walk_req;

  rlb_cmp #(.ENTRIES(ENTRIES)) u_cmp (
    .slot_valid (valid_q),
    .slot_lo    (lo_q),
    .slot_hi    (hi_q),
    .probe      (lk_vpn),
    .covers     (covers)
  );

  rlb_pick #(.ENTRIES(ENTRIES)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .covers  (covers),
    .any_hit (any_hit),
    .win_idx (win_idx)
  );

  rlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_valid (valid_q),
    .write_now  (fill_fire),
    .target     (fill_slot)
  );

  // entry storage: payload needs no reset, valid bits gate it
  always_ff @(posedge clk) begin
    if (fill_fire) begin
      lo_q[fill_slot]   <= fill_base;
      hi_q[fill_slot]   <= fill_limit;
      ofs_q[fill_slot]  <= fill_offset;
      prot_q[fill_slot] <= fill_prot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush_all) begin
      valid_q <= '0;
    end else if (fill_fire) begin
      valid_q[fill_slot] <= 1'b1;
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
      rsp_prot  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_hit  <= any_hit;
        rsp_ppn  <= any_hit ? shift_page(lk_vpn, ofs_q[win_idx]) : '0;
        rsp_prot <= any_hit ? prot_q[win_idx] : '0;
      end
    end
  end

  // walker request, one outstanding at a time
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      walk_req <= 1'b0;
      walk_vpn <= '0;
    end else if (walk_done) begin
      walk_req <= 1'b0;
    end else if (walk_launch) begin
      walk_req <= 1'b1;
      walk_vpn <= lk_vpn;
    end
  end

  AST_RSP_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(lk_valid)); // R3
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R3
  AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !walk_ack) |=> (walk_req && $stable(walk_vpn))); // R4
  AST_WALK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_req); // R4
  AST_MISS_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    walk_launch |=> (walk_req && rsp_valid && !rsp_hit)); // R4
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0)); // R7
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> ($countones(valid_q) >= 1)); // R5
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && rsp_prot == '0)); // R2
endmodule

// File: tb/range_lookaside_test.sv
module range_lookaside_test;
  localparam int N  = 32;
  localparam int VW = 20;
  localparam int PW = 20;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [VW-1:0] lk_vpn = '0;
  logic rsp_valid, rsp_hit, walk_req;
  logic [PW-1:0] rsp_ppn;
  logic [RW-1:0] rsp_prot;
  logic [VW-1:0] walk_vpn;
  logic walk_ack = 1'b0;
  logic fill_valid = 1'b0;
  logic [VW-1:0] fill_base = '0, fill_limit = '0;
  logic [PW-1:0] fill_offset = '0;
  logic [RW-1:0] fill_prot = '0;
  logic flush_all = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the table
  bit            mv [N];
  logic [VW-1:0] mb [N];
  logic [VW-1:0] ml [N];
  logic [PW-1:0] mo [N];
  logic [RW-1:0] mp [N];
  int            mrot = 0;

  always #4 clk = ~clk;

  range_lookaside #(.ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_prot(rsp_prot),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_ack(walk_ack),
    .fill_valid(fill_valid), .fill_base(fill_base), .fill_limit(fill_limit),
    .fill_offset(fill_offset), .fill_prot(fill_prot), .flush_all(flush_all)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] exp_ppn(input logic [VW-1:0] v, input logic [PW-1:0] o);
    longint s;
    s = longint'(v) + longint'(o);
    return PW'(s % (longint'(1) << PW));
  endfunction

  task automatic model_lookup(input logic [VW-1:0] v, output bit h,
                              output logic [PW-1:0] pp, output logic [RW-1:0] pr);
    h = 0; pp = '0; pr = '0;
    for (int i = 0; i < N; i++) begin
      if (!h && mv[i] && v >= mb[i] && v < ml[i]) begin
        h = 1; pp = exp_ppn(v, mo[i]); pr = mp[i];
      end
    end
  endtask

  task automatic model_fill(input logic [VW-1:0] b, input logic [VW-1:0] l,
                            input logic [PW-1:0] o, input logic [RW-1:0] p);
    int slot;
    slot = -1;
    for (int i = 0; i < N; i++) if (slot < 0 && !mv[i]) slot = i;
    if (slot < 0) begin
      slot = mrot;
      mrot = (mrot + 1) % N;
    end
    mv[slot] = 1; mb[slot] = b; ml[slot] = l; mo[slot] = o; mp[slot] = p;
  endtask

  task automatic do_fill(input logic [VW-1:0] b, input logic [VW-1:0] l,
                         input logic [PW-1:0] o, input logic [RW-1:0] p, input bit fl);
    @(negedge clk);
    fill_valid = 1; fill_base = b; fill_limit = l; fill_offset = o; fill_prot = p;
    flush_all = fl;
    @(negedge clk);
    fill_valid = 0; flush_all = 0;
    if (fl) for (int i = 0; i < N; i++) mv[i] = 0;
    else model_fill(b, l, o, p);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_all = 1;
    @(negedge clk);
    flush_all = 0;
    for (int i = 0; i < N; i++) mv[i] = 0;
  endtask

  // lookup with checks; acks the walker on a miss when ack is set
  task automatic do_lookup(input logic [VW-1:0] v, input bit ack, input string req);
    bit h; logic [PW-1:0] pp; logic [RW-1:0] pr;
    model_lookup(v, h, pp, pr);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v;
    @(negedge clk);
    lk_valid = 0;
    chk(rsp_valid === 1'b1, {req, " R3 rsp_valid"}, rsp_valid, 1);
    chk(rsp_hit === h, {req, " R1 hit"}, rsp_hit, h);
    chk(rsp_ppn === pp, {req, " R2 ppn"}, rsp_ppn, pp);
    chk(rsp_prot === pr, {req, " R2 prot"}, rsp_prot, pr);
    if (ack) begin
      chk(walk_req === !h, {req, " R4 walk_req"}, walk_req, !h);
      if (!h) begin
        chk(walk_vpn === v, {req, " R4 walk_vpn"}, walk_vpn, v);
        walk_ack = 1;
        @(negedge clk);
        walk_ack = 0;
        chk(walk_req === 1'b0, {req, " R4 drop"}, walk_req, 0);
      end else begin
        @(negedge clk);
      end
      chk(rsp_valid === 1'b0, {req, " R3 single"}, rsp_valid, 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) mv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(rsp_valid === 1'b0, "R9 rsp_valid", rsp_valid, 0);
    chk(walk_req === 1'b0, "R9 walk_req", walk_req, 0);
    do_lookup(20'd100, 1, "R9 empty");

    // R1/R2 bounds
    do_fill(20'd100, 20'd110, 20'd1000, 4'h5, 0);
    do_lookup(20'd99, 1, "R1 below");
    do_lookup(20'd100, 1, "R1 base");
    do_lookup(20'd109, 1, "R1 last");
    do_lookup(20'd110, 1, "R1 limit");
    // R2 wrap of the physical width
    do_fill(20'd200, 20'd210, 20'hFFFF0, 4'hA, 0);
    do_lookup(20'd205, 1, "R2 wrap");
    // R1 inverted span never hits
    do_fill(20'd300, 20'd300, 20'd1, 4'h1, 0);
    do_lookup(20'd300, 1, "R1 empty span");

    // R8 / R5 overlap: earlier fill sits in a lower slot and wins
    do_fill(20'd105, 20'd120, 20'd7, 4'h3, 0);
    do_lookup(20'd107, 1, "R8 R5 overlap");
    do_lookup(20'd115, 1, "R8 second only");

    // R4 hold without ack, second miss ignored
    @(negedge clk); lk_valid = 1; lk_vpn = 20'd500;
    @(negedge clk); lk_valid = 0;
    repeat (3) @(negedge clk);
    chk(walk_req === 1'b1 && walk_vpn === 20'd500, "R4 held", walk_vpn, 500);
    @(negedge clk); lk_valid = 1; lk_vpn = 20'd600;
    @(negedge clk); lk_valid = 0;
    chk(walk_vpn === 20'd500, "R4 second miss ignored", walk_vpn, 500);
    walk_ack = 1;
    @(negedge clk); walk_ack = 0;
    chk(walk_req === 1'b0, "R4 ack drops", walk_req, 0);

    // R10 lookup in the same cycle as a refill sees old contents
    @(negedge clk);
    lk_valid = 1; lk_vpn = 20'd700;
    fill_valid = 1; fill_base = 20'd700; fill_limit = 20'd701; fill_offset = 20'd3; fill_prot = 4'h2;
    @(negedge clk);
    lk_valid = 0; fill_valid = 0;
    model_fill(20'd700, 20'd701, 20'd3, 4'h2);
    chk(rsp_hit === 1'b0, "R10 old contents", rsp_hit, 0);
    walk_ack = 1; @(negedge clk); walk_ack = 0;
    do_lookup(20'd700, 1, "R10 new visible");

    // R7 flush with a same-cycle refill
    do_fill(20'd800, 20'd810, 20'd9, 4'h4, 1);
    do_lookup(20'd805, 1, "R7 fill dropped");
    do_lookup(20'd100, 1, "R7 flushed");

    // R5 then R6: fill all slots, then rotate
    for (int k = 0; k < N; k++) do_fill(VW'(k * 16), VW'(k * 16 + 8), PW'(k), 4'h6, 0);
    do_lookup(20'd0, 1, "R5 slot0");
    do_lookup(VW'((N - 1) * 16 + 7), 1, "R5 last slot");
    do_fill(20'd5000, 20'd5010, 20'd11, 4'h7, 0);
    do_lookup(20'd0, 1, "R6 slot0 replaced");
    do_lookup(20'd16, 1, "R6 slot1 kept");
    do_lookup(20'd5000, 1, "R6 new entry");
    do_fill(20'd6000, 20'd6010, 20'd12, 4'h8, 0);
    do_lookup(20'd16, 1, "R6 slot1 replaced");
    do_lookup(20'd32, 1, "R6 slot2 kept");

    // random phase: R1 R2 R5 R6 R8 against the model
    do_flush();
    for (int r = 0; r < 48; r++) begin
      logic [VW-1:0] b, l;
      b = VW'($urandom % 4000);
      l = b + VW'(1 + $urandom % 80);
      do_fill(b, l, PW'($urandom), RW'($urandom), 0);
      for (int q = 0; q < 5; q++) begin
        int s, sel;
        logic [VW-1:0] v;
        s = $urandom % N;
        sel = $urandom % 4;
        if (!mv[s]) v = VW'($urandom % 4100);
        else if (sel == 0) v = mb[s];
        else if (sel == 1) v = ml[s] - 1;
        else if (sel == 2) v = ml[s];
        else v = VW'($urandom % 4100);
        do_lookup(v, 1, "R1 R2 R8 random");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule